// File: doc/BRIEF.md
# Interrupt group acceptance resolver

This block sits beside a small microcontroller's interrupt controller and answers one question for the CPU: which interrupt group should be served now? Every group has a pending flag and a 3-bit priority level. The CPU supplies its current 3-bit mask level. A group counts as accepted when it is pending and its level is strictly lower than the mask. Level 0 is the most urgent, so a mask of 0 accepts nothing and level 7 is never accepted. On a read, the group register returns the smallest accepted group number. Interrupt entry code can add this number to the base of a vector table.

The block also holds seven 16-bit per-level vector registers. It continuously forms a 32-bit handler start address for the most urgent accepted level. The upper half of that address is fixed at 0x4000 and the lower half comes from the vector register of that level. A valid flag marks when the address means anything. Software reaches both kinds of register through a simple bus with address, read and write strobes, a byte-access flag and 16-bit data.

Top module: `igr_resolver`

## Requirements
- R1: A halfword read of address 0x34000200 returns the smallest group number i whose pending bit is 1 and whose level, held in `grp_lvl[3*i+2:3*i]`, is strictly lower than `cpu_mask`. The number sits in bits 4:0 and bits 15:5 are 0.
- R2: The group register reads as 0 when no pending group has an accepted level. This is always so when `cpu_mask` is 0, and a group at level 7 is never accepted.
- R3: `bus_rdata` is registered. It shows the read result in the cycle after `bus_rd` is sampled high, computed from the inputs in the strobe cycle. It is 0 in any cycle that follows a cycle without a read.
- R4: Writes to the group register address are ignored. They change neither the group read value nor any vector register.
- R5: With `bus_byte`=1, a read of 0x34000200 returns bits 7:0 and a read of 0x34000201 returns bits 15:8 of the group register. The byte comes back zero-extended in `bus_rdata[7:0]`.
- R6: A halfword write to 0x20000000+4*n, for n from 0 to 6, loads vector register n, and a halfword read at that address returns it. Vector registers change only through such writes.
- R7: Byte accesses (`bus_byte`=1) to vector register addresses return 0 and do not write.
- R8: Reads of any other address return 0 and writes to it have no effect, for example 0x2000001C or 0x20000002.
- R9: When some group is accepted, `hdl_valid` is 1 and `hdl_addr` is {0x4000, vector register L}, where L is the lowest level number among accepted groups. Otherwise `hdl_valid` is 0 and `hdl_addr` is 0.
- R10: After reset `bus_rdata` is 0. Vector registers have no defined reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Bus byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_byte | input | 1 | 1 for a byte access, 0 for a halfword access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| grp_pend | input | 32 | Pending flag of each group |
| grp_lvl | input | 96 | 3-bit level of each group, group i in bits 3i+2:3i |
| cpu_mask | input | 3 | CPU interrupt mask level |
| hdl_addr | output | 32 | Handler start address for the most urgent accepted level |
| hdl_valid | output | 1 | At least one group is accepted |

## Verification
A bus read of the group register and a change of the pending, level or mask inputs can fall in the same cycle. The bench changes those inputs immediately after a read strobe and requires the registered read data to match the inputs of the strobe cycle, not the new ones. A vector register write can also land while the handler address is selecting that same level. The bench rewrites the vector register that feeds the current handler address. It then requires the new lower half to appear once the write edge has passed, with the group read result unchanged.

// File: rtl/igr_pkg.sv
// Shared constants for the interrupt group acceptance resolver.
// Assumes a 32-bit byte-addressed bus and 16-bit registers.
package igr_pkg;
    localparam logic [31:0] GRP_ADDR   = 32'h3400_0200;
    localparam logic [31:0] VEC_BASE   = 32'h2000_0000;
    localparam logic [15:0] HDL_UPPER  = 16'h4000;
endpackage

// File: rtl/igr_accept_scan.sv
// Acceptance scan: marks every pending group whose level is below the
// mask, then reports the lowest such group number and the lowest level
// among them. Purely combinational; assumes NUM_GROUPS <= 2**GN_W.
module igr_accept_scan #(
    parameter int NUM_GROUPS = 32,
    parameter int LVL_W      = 3,
    parameter int GN_W       = 5
) (
    input  logic [NUM_GROUPS-1:0]       pend,
    input  logic [NUM_GROUPS*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]            mask,
    output logic [GN_W-1:0]             grp_num,
    output logic                        any_hit,
    output logic [LVL_W-1:0]            best_lvl
);
    logic [NUM_GROUPS-1:0] acc;

    // Per-group acceptance: pending and strictly more urgent than the mask.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_acc
        assign acc[g] = pend[g] && (lvl[g*LVL_W +: LVL_W] < mask);
    end

    // Lowest accepted group number and lowest accepted level.
    always_comb begin
        grp_num  = '0;
        any_hit  = 1'b0;
        best_lvl = '1;
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (acc[i] && !any_hit) begin
                grp_num = GN_W'(i);
                any_hit = 1'b1;
            end
            if (acc[i] && (lvl[i*LVL_W +: LVL_W] < best_lvl)) begin
                best_lvl = lvl[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/igr_vec_bank.sv
// Per-level vector register bank with one write port, one bus read port
// and one handler-select port. Contents are deliberately not reset;
// writes are held off while reset is asserted. Assumes
// NUM_LEVELS <= 2**LVL_W; an index at or past NUM_LEVELS reads 0.
module igr_vec_bank #(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 3,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LVL_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  sel_lvl,
    output logic [DATA_W-1:0] sel_data
);
    logic [DATA_W-1:0] vec_q [NUM_LEVELS];

    // One storage register per level, loaded by a matching write.
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst_n && wr_en && (wr_idx == LVL_W'(l))) begin
                vec_q[l] <= wr_data;
            end
        end
    end

    // Bus read and handler select multiplexers.
    always_comb begin
        rd_data  = '0;
        sel_data = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (rd_idx == LVL_W'(l)) rd_data = vec_q[l];
            if (sel_lvl == LVL_W'(l)) sel_data = vec_q[l];
        end
    end
endmodule

// File: rtl/igr_bus_decode.sv
// Address decoder and read-data selector for the resolver registers.
// Group register: halfword read at GRP_ADDR, byte reads at GRP_ADDR and
// GRP_ADDR+1. Vector registers: halfword only, 4-byte stride from
// VEC_BASE. All else reads 0 and ignores writes. Combinational.
module igr_bus_decode
    import igr_pkg::*;
#(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 3,
    parameter int DATA_W     = 16
) (
    input  logic [31:0]       addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] grp_value,
    input  logic [DATA_W-1:0] vec_rd_data,
    output logic              vec_wr_en,
    output logic [LVL_W-1:0]  vec_idx,
    output logic [DATA_W-1:0] rdata_d
);
    logic [31:0] vec_off;
    logic        vec_hit;
    logic        grp_half;
    logic        grp_lo;
    logic        grp_hi;

    // Region matching for vector and group registers.
    always_comb begin
        vec_off  = addr - VEC_BASE;
        vec_hit  = (vec_off[1:0] == 2'b00) && ({2'b00, vec_off[31:2]} < 32'(NUM_LEVELS));
        vec_idx  = vec_off[LVL_W+1:2];
        grp_half = !byte_sel && (addr == GRP_ADDR);
        grp_lo   = byte_sel && (addr == GRP_ADDR);
        grp_hi   = byte_sel && (addr == GRP_ADDR + 32'd1);
    end

    assign vec_wr_en = wr && vec_hit && !byte_sel;

    // Next read data selection; 0 when no read or no match.
    always_comb begin
        rdata_d = '0;
        if (rd) begin
            if (grp_half)                 rdata_d = grp_value;
            else if (grp_lo)              rdata_d = DATA_W'(grp_value[7:0]);
            else if (grp_hi)              rdata_d = DATA_W'(grp_value[15:8]);
            else if (vec_hit && !byte_sel) rdata_d = vec_rd_data;
        end
    end
endmodule

// File: rtl/igr_resolver.sv
// Interrupt group acceptance resolver top. Reports the lowest accepted
// pending group through a read-only register and drives a handler start
// address for the most urgent accepted level. Read data is registered
// one cycle after the strobe; handler outputs are combinational.
module igr_resolver
    import igr_pkg::*;
#(
    parameter int NUM_GROUPS = 32,
    parameter int LVL_W      = 3,
    parameter int NUM_LEVELS = 7,
    parameter int DATA_W     = 16,
    localparam int GN_W      = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [31:0]                 bus_addr,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic                        bus_byte,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_GROUPS-1:0]       grp_pend,
    input  logic [NUM_GROUPS*LVL_W-1:0] grp_lvl,
    input  logic [LVL_W-1:0]            cpu_mask,
    output logic [31:0]                 hdl_addr,
    output logic                        hdl_valid
);
    logic [GN_W-1:0]   grp_num;
    logic              any_hit;
    logic [LVL_W-1:0]  best_lvl;
    logic [DATA_W-1:0] grp_value;
    logic [DATA_W-1:0] vec_rd_data;
    logic [DATA_W-1:0] sel_data;
    logic              vec_wr_en;
    logic [LVL_W-1:0]  vec_idx;
    logic [DATA_W-1:0] rdata_d;

    igr_accept_scan #(
        .NUM_GROUPS(NUM_GROUPS), .LVL_W(LVL_W), .GN_W(GN_W)
    ) u_scan (
        .pend(grp_pend), .lvl(grp_lvl), .mask(cpu_mask),
        .grp_num(grp_num), .any_hit(any_hit), .best_lvl(best_lvl)
    );

    assign grp_value = DATA_W'(grp_num);

    igr_vec_bank #(
        .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .DATA_W(DATA_W)
    ) u_vec (
        .clk(clk), .rst_n(rst_n), .wr_en(vec_wr_en), .wr_idx(vec_idx),
        .wr_data(bus_wdata), .rd_idx(vec_idx), .rd_data(vec_rd_data),
        .sel_lvl(best_lvl), .sel_data(sel_data)
    );

    igr_bus_decode #(
        .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .DATA_W(DATA_W)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .byte_sel(bus_byte),
        .grp_value(grp_value), .vec_rd_data(vec_rd_data),
        .vec_wr_en(vec_wr_en), .vec_idx(vec_idx), .rdata_d(rdata_d)
    );

    // Read data register, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rdata_d;
    end

    // Handler start address, 0 when nothing is accepted.
    always_comb begin
        hdl_valid = any_hit;
        hdl_addr  = any_hit ? {HDL_UPPER, sel_data} : 32'h0;
    end
endmodule

// File: rtl/igr_resolver_chk.sv
// Assertion checker for igr_resolver, attached by bind below.
module igr_resolver_chk
    import igr_pkg::*;
#(
    parameter int NUM_GROUPS = 32,
    parameter int LVL_W      = 3,
    parameter int DATA_W     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [31:0]                 bus_addr,
    input logic                        bus_rd,
    input logic                        bus_wr,
    input logic                        bus_byte,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_GROUPS-1:0]       grp_pend,
    input logic [NUM_GROUPS*LVL_W-1:0] grp_lvl,
    input logic [LVL_W-1:0]            cpu_mask,
    input logic [31:0]                 hdl_addr,
    input logic                        hdl_valid
);
    // R3: no read in the previous cycle means zero read data.
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));

    // R1: halfword group read never sets bits above the group number.
    a_r1_group_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && !$past(bus_byte) && ($past(bus_addr) == GRP_ADDR))
        |-> (bus_rdata[DATA_W-1:5] == '0));

    // R9: a valid handler address needs some pending group.
    a_r9_valid_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_valid |-> (grp_pend != '0));

    // R2: a zero mask accepts nothing.
    a_r2_mask_zero_none: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask == '0) |-> !hdl_valid);

    // R6: without a write and with steady inputs the handler address holds.
    a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_wr) && $stable(grp_pend) && $stable(grp_lvl) && $stable(cpu_mask))
        |-> $stable(hdl_addr));
endmodule

bind igr_resolver igr_resolver_chk #(
    .NUM_GROUPS(NUM_GROUPS), .LVL_W(LVL_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_rdata(bus_rdata),
    .grp_pend(grp_pend), .grp_lvl(grp_lvl), .cpu_mask(cpu_mask),
    .hdl_addr(hdl_addr), .hdl_valid(hdl_valid)
);

// File: tb/tb_igr_resolver.sv
module tb_igr_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] grp_pend = '0;
    logic [95:0] grp_lvl = '0;
    logic [2:0]  cpu_mask = '0;
    logic [31:0] hdl_addr;
    logic        hdl_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] vec_m [7];

    localparam logic [31:0] GA = 32'h3400_0200;
    localparam logic [31:0] VB = 32'h2000_0000;

    always #2.5 clk = ~clk;

    igr_resolver dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .grp_pend(grp_pend), .grp_lvl(grp_lvl),
        .cpu_mask(cpu_mask), .hdl_addr(hdl_addr), .hdl_valid(hdl_valid)
    );

    function automatic logic [15:0] exp_grp(logic [31:0] p, logic [95:0] l, logic [2:0] m);
        for (int i = 0; i < 32; i++)
            if (p[i] && (l[3*i +: 3] < m)) return 16'(i);
        return 16'h0;
    endfunction

    function automatic logic [32:0] exp_hdl(logic [31:0] p, logic [95:0] l, logic [2:0] m);
        logic [2:0] best = 3'd7;
        logic hit = 1'b0;
        for (int i = 0; i < 32; i++)
            if (p[i] && (l[3*i +: 3] < m)) begin
                hit = 1'b1;
                if (l[3*i +: 3] < best) best = l[3*i +: 3];
            end
        return hit ? {1'b1, 16'h4000, vec_m[best]} : 33'h0;
    endfunction

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic b, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_byte = b; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_write(input logic [31:0] a, input logic b, input logic [15:0] w);
        @(negedge clk);
        bus_addr = a; bus_byte = b; bus_wdata = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_hdl(input string tag);
        #1;
        chk(tag, {hdl_valid, hdl_addr}, exp_hdl(grp_pend, grp_lvl, cpu_mask));
    endtask

    task automatic set_in(input logic [31:0] p, input logic [95:0] l, input logic [2:0] m);
        @(negedge clk);
        grp_pend = p; grp_lvl = l; cpu_mask = m;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] e;
        logic [31:0] seed;
        seed = $urandom(32'd4711);
        bus_rd = 1'b1; bus_addr = GA;
        repeat (3) @(negedge clk);
        bus_rd = 1'b0;
        rst_n = 1'b1;
        #1;
        chk("R10 reset read data", 33'(bus_rdata), 33'h0);

        // R6: load and read back every vector register.
        for (int l = 0; l < 7; l++) begin
            vec_m[l] = 16'($urandom);
            do_write(VB + 32'(4*l), 1'b0, vec_m[l]);
        end
        for (int l = 0; l < 7; l++) begin
            do_read(VB + 32'(4*l), 1'b0, d);
            chk("R6 vector readback", 33'(d), 33'(vec_m[l]));
        end

        // R3: cycle after a read with no new strobe returns 0.
        @(negedge clk); #1;
        chk("R3 idle read data", 33'(bus_rdata), 33'h0);

        // R2: mask zero accepts nothing; level 7 never accepted.
        set_in(32'hFFFF_FFFF, 96'h0, 3'd0);
        do_read(GA, 1'b0, d);
        chk("R2 mask zero group", 33'(d), 33'h0);
        check_hdl("R9 mask zero handler");
        set_in(32'hFFFF_FFFF, {32{3'd7}}, 3'd7);
        do_read(GA, 1'b0, d);
        chk("R2 all level 7 group", 33'(d), 33'h0);
        check_hdl("R9 all level 7 handler");

        // R1: only group 31 accepted, at level 6 under mask 7.
        set_in(32'h8000_0000, {3'd6, {31{3'd0}}}, 3'd7);
        do_read(GA, 1'b0, d);
        chk("R1 group 31 only", 33'(d), 33'd31);
        check_hdl("R9 level 6 handler");

        // R5: byte reads of group register.
        do_read(GA, 1'b1, d);
        chk("R5 byte low", 33'(d), 33'd31);
        do_read(GA + 32'd1, 1'b1, d);
        chk("R5 byte high", 33'(d), 33'd0);

        // R4: write to group register ignored.
        do_write(GA, 1'b0, 16'hFFFF);
        do_read(GA, 1'b0, d);
        chk("R4 group after write", 33'(d), 33'd31);
        do_read(VB, 1'b0, d);
        chk("R4 vector after group write", 33'(d), 33'(vec_m[0]));

        // R7: byte access to vector registers.
        do_write(VB + 32'd24, 1'b1, ~vec_m[6]);
        do_read(VB + 32'd24, 1'b1, d);
        chk("R7 byte vector read", 33'(d), 33'h0);
        do_read(VB + 32'd24, 1'b0, d);
        chk("R7 byte write ignored", 33'(d), 33'(vec_m[6]));

        // R8: unmapped addresses.
        do_write(VB + 32'd28, 1'b0, 16'h1234);
        do_write(VB + 32'd2, 1'b0, 16'h5678);
        do_read(VB + 32'd28, 1'b0, d);
        chk("R8 unmapped read", 33'(d), 33'h0);
        do_read(VB + 32'd2, 1'b0, d);
        chk("R8 misaligned read", 33'(d), 33'h0);
        for (int l = 0; l < 7; l++) begin
            do_read(VB + 32'(4*l), 1'b0, d);
            chk("R8 vectors unchanged", 33'(d), 33'(vec_m[l]));
        end

        // R3: inputs change right after the strobe; data follows strobe cycle.
        set_in(32'h0000_0010, 96'h0, 3'd1);
        @(negedge clk);
        bus_addr = GA; bus_byte = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; grp_pend = 32'h0000_0002;
        #1;
        chk("R3 strobe cycle sampling", 33'(bus_rdata), 33'd4);

        // R6/R9: rewrite the vector feeding the current handler address.
        check_hdl("R9 before vector rewrite");
        vec_m[0] = 16'hBEEF;
        do_write(VB, 1'b0, 16'hBEEF);
        check_hdl("R6 handler follows rewrite");

        // R1/R9: constrained random patterns.
        for (int it = 0; it < 400; it++) begin
            logic [31:0] p;
            p = $urandom & $urandom;
            if (it % 4 == 0) p = 32'h1 << ($urandom % 32);
            set_in(p, {$urandom, $urandom, $urandom}, 3'($urandom));
            e = exp_grp(grp_pend, grp_lvl, cpu_mask);
            check_hdl("R9 random handler");
            do_read(GA, 1'b0, d);
            chk("R1 random group", 33'(d), 33'(e));
            if (it % 16 == 0) begin
                do_read(GA, 1'b1, d);
                chk("R5 random byte low", 33'(d), 33'(e[7:0]));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule